// File: doc/BRIEF.md
# Adaptive Diagnostic Tree Sequencer

This block steps through a stored binary decision tree to isolate a single fault in a device under test. At every internal node it asks for one test vector by index. It holds the request until a response comes back saying whether the device passed or failed that vector. The result selects the pass child or the fail child as the next node. The sequence is therefore adaptive: each vector is chosen from the outcome of the test before it, not taken from a fixed list.

When the walk lands on a leaf, the block pulses a completion strobe and presents a diagnosis code. That code either names one fault or reports a fault-free device. The tree is built at elaboration from parameters and needs no external file. It holds one internal node per test vector (eleven by default) and one more leaf than that. The layout is heap-shaped and close to balanced, so each test splits the remaining candidates roughly in half.

A step guard counts the tests issued in one walk. If another test would exceed the configured limit, the walk ends with an abort flag and a reserved error code.

Top module: `diag_tree_seq`

## Requirements
- R1: After reset, `busy`, `vec_valid` and `done` are low.
- R2: A `start` sampled high while idle begins a walk at node 0. `busy` is high in the next cycle, and `vec_valid` with vector index 0 follows one cycle later.
- R3: `vec_valid` stays high and `vec_idx` stays stable until `resp_valid` is sampled high. A `resp_valid` pulse while `vec_valid` is low has no effect.
- R4: Internal node n, for n below N_VEC (11), issues vector index n. A pass response (`resp_fail`=0) moves to node 2n+1. A fail response moves to node 2n+2. Nodes N_VEC through 2*N_VEC are leaves.
- R5: Leaf n reports code (n - 15 + 12) mod 12, so codes range from 0 to 11. The all-pass path ends on leaf 15, which gives code 0 and means no fault is present.
- R6: `done` is a one-cycle pulse. `busy` is low in that cycle. A walk issues at least 3 and at most 4 tests.
- R7: A `start` seen while `busy` is high is ignored. The walk in progress continues unchanged.
- R8: If a further test would make the number of tests exceed MAX_STEPS, the walk ends with `done` and `diag_abort` high, and `diag_code` equal to 15. With MAX_STEPS=3, the all-pass pattern aborts. The pattern fail, pass, pass still completes, with code 8.
- R9: A `start` presented in the same cycle as `done` is accepted and begins a new walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk at node 0 when idle |
| resp_valid | input | 1 | One-cycle response strobe |
| resp_fail | input | 1 | Response outcome, 1 = device failed the vector |
| vec_valid | output | 1 | Vector request pending |
| vec_idx | output | VEC_W (4) | Index of the requested vector |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion strobe |
| diag_code | output | CODE_W (4) | Diagnosis code, valid with `done` |
| diag_abort | output | 1 | Walk ended by the step limit, valid with `done` |

## Verification
The completion strobe of one walk and the acceptance of the next `start` can fall in the same cycle. The bench provokes this by raising `start` in the very sample where it sees `done`. It then judges that `busy` rises and that the new vector sequence matches the model from node 0. A second overlap is a `start` sent while a vector request is still held. Here the bench checks that the request stays put and that the walk still reaches the expected leaf. A second instance with a small step limit covers the abort path.

// File: rtl/diag_pkg.sv
package diag_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_EVAL = 2'd1,
      ST_WAIT = 2'd2
   } walk_state_e;

   // Leaf numbering: rotate so that the all-pass leaf maps to code 0.
   function automatic int leaf_code(input int node, input int pass_leaf, input int n_leaf);
      return (node - pass_leaf + n_leaf) % n_leaf;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/diag_tree_rom.sv
module diag_tree_rom
   import diag_pkg::*;
#(
   parameter int N_VEC   = 11,
   parameter int N_NODES = 2 * N_VEC + 1,
   parameter int ADDR_W  = $clog2(N_NODES),
   parameter int PAY_W   = 4,
   parameter int CODE_W  = 4
) (
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_leaf,
   output logic [PAY_W-1:0]  rd_pay,
   output logic [ADDR_W-1:0] rd_pass,
   output logic [ADDR_W-1:0] rd_fail
);

   localparam int N_LEAF    = N_VEC + 1;
   localparam int PASS_LEAF = (1 << $clog2(N_LEAF)) - 1;
   localparam int ERR_CODE  = (1 << CODE_W) - 1;

   logic              leaf_tab [N_NODES];
   logic [PAY_W-1:0]  pay_tab  [N_NODES];
   logic [ADDR_W-1:0] pass_tab [N_NODES];
   logic [ADDR_W-1:0] fail_tab [N_NODES];

   if (N_NODES != 2 * N_VEC + 1) begin : g_bad_nodes
      $error("diag_tree_rom: node count must equal 2*N_VEC+1");
   end
   if (N_LEAF > ERR_CODE) begin : g_bad_code
      $error("diag_tree_rom: CODE_W too narrow for leaf codes plus error code");
   end

   for (genvar i = 0; i < N_NODES; i++) begin : g_node
      if (i < N_VEC) begin : g_inner
         assign leaf_tab[i] = 1'b0;
         assign pay_tab[i]  = PAY_W'(i);
         assign pass_tab[i] = ADDR_W'(2 * i + 1);
         assign fail_tab[i] = ADDR_W'(2 * i + 2);
      end else begin : g_leaf
         assign leaf_tab[i] = 1'b1;
         assign pay_tab[i]  = PAY_W'(leaf_code(i, PASS_LEAF, N_LEAF));
         assign pass_tab[i] = ADDR_W'(i);
         assign fail_tab[i] = ADDR_W'(i);
      end
   end

   // Addresses past the table read as an error leaf.
   always_comb begin
      if (int'(rd_addr) < N_NODES) begin
         rd_leaf = leaf_tab[rd_addr];
         rd_pay  = pay_tab[rd_addr];
         rd_pass = pass_tab[rd_addr];
         rd_fail = fail_tab[rd_addr];
      end else begin
         rd_leaf = 1'b1;
         rd_pay  = PAY_W'(ERR_CODE);
         rd_pass = rd_addr;
         rd_fail = rd_addr;
      end
   end

endmodule

// File: rtl/diag_step_guard.sv
module diag_step_guard #(
   parameter int LIMIT = 23,
   parameter int CNT_W = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic at_limit
);

   logic [CNT_W-1:0] cnt_q;

   if (LIMIT < 1) begin : g_bad_limit
      $error("diag_step_guard: LIMIT must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (step && !at_limit) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign at_limit = (int'(cnt_q) >= LIMIT);

endmodule

// File: rtl/diag_walk_fsm.sv
module diag_walk_fsm
   import diag_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int PAY_W  = 4,
   parameter int VEC_W  = 4,
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              resp_valid,
   input  logic              resp_fail,
   input  logic              rd_leaf,
   input  logic [PAY_W-1:0]  rd_pay,
   input  logic [ADDR_W-1:0] rd_pass,
   input  logic [ADDR_W-1:0] rd_fail,
   input  logic              at_limit,
   output logic [ADDR_W-1:0] node_addr,
   output logic              step,
   output logic              clear,
   output logic              vec_valid,
   output logic [VEC_W-1:0]  vec_idx,
   output logic              busy,
   output logic              done,
   output logic [CODE_W-1:0] diag_code,
   output logic              diag_abort
);

   localparam logic [CODE_W-1:0] ERR_CODE = '1;

   walk_state_e       state_q;
   logic [ADDR_W-1:0] node_q;

   if (VEC_W > PAY_W || CODE_W > PAY_W) begin : g_bad_pay
      $error("diag_walk_fsm: payload narrower than vector or code field");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         node_q     <= '0;
         done       <= 1'b0;
         diag_abort <= 1'b0;
         diag_code  <= '0;
      end else begin
         done       <= 1'b0;
         diag_abort <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  node_q  <= '0;
                  state_q <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               if (rd_leaf) begin
                  done      <= 1'b1;
                  diag_code <= rd_pay[CODE_W-1:0];
                  state_q   <= ST_IDLE;
               end else if (at_limit) begin
                  done       <= 1'b1;
                  diag_abort <= 1'b1;
                  diag_code  <= ERR_CODE;
                  state_q    <= ST_IDLE;
               end else begin
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (resp_valid) begin
                  node_q  <= resp_fail ? rd_fail : rd_pass;
                  state_q <= ST_EVAL;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign node_addr = node_q;
   assign clear     = (state_q == ST_IDLE) && start;
   assign step      = (state_q == ST_EVAL) && !rd_leaf && !at_limit;
   assign vec_valid = (state_q == ST_WAIT);
   assign vec_idx   = rd_pay[VEC_W-1:0];
   assign busy      = (state_q != ST_IDLE);

endmodule

// File: rtl/diag_tree_seq.sv
module diag_tree_seq
   import diag_pkg::*;
#(
   parameter int N_VEC     = 11,
   parameter int MAX_STEPS = 2 * N_VEC + 1,
   parameter int VEC_W     = (N_VEC > 1) ? $clog2(N_VEC) : 1,
   parameter int CODE_W    = $clog2(N_VEC + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              resp_valid,
   input  logic              resp_fail,
   output logic              vec_valid,
   output logic [VEC_W-1:0]  vec_idx,
   output logic              busy,
   output logic              done,
   output logic [CODE_W-1:0] diag_code,
   output logic              diag_abort
);

   localparam int N_NODES = 2 * N_VEC + 1;
   localparam int ADDR_W  = $clog2(N_NODES);
   localparam int PAY_W   = max2(VEC_W, CODE_W);

   if (N_VEC < 1) begin : g_bad_vec
      $error("diag_tree_seq: N_VEC must be at least 1");
   end
   if ((1 << VEC_W) < N_VEC) begin : g_bad_vecw
      $error("diag_tree_seq: VEC_W cannot index all vectors");
   end

   logic              rd_leaf;
   logic [PAY_W-1:0]  rd_pay;
   logic [ADDR_W-1:0] rd_pass;
   logic [ADDR_W-1:0] rd_fail;
   logic [ADDR_W-1:0] node_addr;
   logic              step;
   logic              clear;
   logic              at_limit;

   diag_tree_rom #(
      .N_VEC  (N_VEC),
      .N_NODES(N_NODES),
      .ADDR_W (ADDR_W),
      .PAY_W  (PAY_W),
      .CODE_W (CODE_W)
   ) rom_i (
      .rd_addr(node_addr),
      .rd_leaf(rd_leaf),
      .rd_pay (rd_pay),
      .rd_pass(rd_pass),
      .rd_fail(rd_fail)
   );

   diag_step_guard #(
      .LIMIT(MAX_STEPS)
   ) guard_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .step    (step),
      .at_limit(at_limit)
   );

   diag_walk_fsm #(
      .ADDR_W(ADDR_W),
      .PAY_W (PAY_W),
      .VEC_W (VEC_W),
      .CODE_W(CODE_W)
   ) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .resp_valid(resp_valid),
      .resp_fail (resp_fail),
      .rd_leaf   (rd_leaf),
      .rd_pay    (rd_pay),
      .rd_pass   (rd_pass),
      .rd_fail   (rd_fail),
      .at_limit  (at_limit),
      .node_addr (node_addr),
      .step      (step),
      .clear     (clear),
      .vec_valid (vec_valid),
      .vec_idx   (vec_idx),
      .busy      (busy),
      .done      (done),
      .diag_code (diag_code),
      .diag_abort(diag_abort)
   );

endmodule

// File: rtl/diag_tree_seq_chk.sv
module diag_tree_seq_chk #(
   parameter int N_VEC  = 11,
   parameter int VEC_W  = 4,
   parameter int CODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              resp_valid,
   input logic              vec_valid,
   input logic [VEC_W-1:0]  vec_idx,
   input logic              busy,
   input logic              done,
   input logic [CODE_W-1:0] diag_code,
   input logic              diag_abort
);

   localparam logic [CODE_W-1:0] ERR_CODE = '1;

   a_r2_start_begins: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   a_r3_request_held: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_valid && !resp_valid) |=> (vec_valid && $stable(vec_idx)));

   a_r4_index_range: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (int'(vec_idx) < N_VEC));

   a_r5_code_range: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !diag_abort) |-> (int'(diag_code) <= N_VEC));

   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !vec_valid));

   a_r8_abort_code: assert property (@(posedge clk) disable iff (!rst_n)
      diag_abort |-> (done && diag_code == ERR_CODE));

endmodule

bind diag_tree_seq diag_tree_seq_chk #(
   .N_VEC (N_VEC),
   .VEC_W (VEC_W),
   .CODE_W(CODE_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .resp_valid(resp_valid),
   .vec_valid (vec_valid),
   .vec_idx   (vec_idx),
   .busy      (busy),
   .done      (done),
   .diag_code (diag_code),
   .diag_abort(diag_abort)
);

// File: tb/diag_tree_seq_tb_top.sv
module diag_tree_seq_tb_top;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n      = 1'b0;
   logic start      = 1'b0;
   logic resp_valid = 1'b0;
   logic resp_fail  = 1'b0;
   logic sel        = 1'b0;

   logic       vv0, vv1, b0, b1, d0, d1, a0, a1;
   logic [3:0] vi0, vi1, c0, c1;

   logic       vv, bz, dn, ab;
   logic [3:0] vi, cd;

   int errs   = 0;
   int checks = 0;
   int exp_code_q[$];
   int exp_abort_q[$];

   diag_tree_seq dut_i (
      .clk(clk), .rst_n(rst_n),
      .start(start & ~sel), .resp_valid(resp_valid & ~sel), .resp_fail(resp_fail),
      .vec_valid(vv0), .vec_idx(vi0), .busy(b0), .done(d0),
      .diag_code(c0), .diag_abort(a0));

   diag_tree_seq #(.MAX_STEPS(3)) dut_lim_i (
      .clk(clk), .rst_n(rst_n),
      .start(start & sel), .resp_valid(resp_valid & sel), .resp_fail(resp_fail),
      .vec_valid(vv1), .vec_idx(vi1), .busy(b1), .done(d1),
      .diag_code(c1), .diag_abort(a1));

   assign vv = sel ? vv1 : vv0;
   assign vi = sel ? vi1 : vi0;
   assign bz = sel ? b1  : b0;
   assign dn = sel ? d1  : d0;
   assign cd = sel ? c1  : c0;
   assign ab = sel ? a1  : a0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard whenever a walk completes.
   always @(negedge clk) begin
      if (rst_n && dn) begin
         if (exp_code_q.size() == 0) begin
            chk(1'b0, "R6 unexpected done", 1, 0);
         end else begin
            int ec;
            int ea;
            ec = exp_code_q.pop_front();
            ea = exp_abort_q.pop_front();
            chk(int'(cd) == ec, "R5 R8 diagnosis code", int'(cd), ec);
            chk(int'(ab) == ea, "R8 abort flag", int'(ab), ea);
            chk(!bz, "R6 busy low with done", int'(bz), 0);
         end
      end
   end

   // Driver: computes the expected walk, pushes the outcome, plays the responder.
   task automatic run_walk(input logic [3:0] pat, input int lat, input bit poke, input int limit);
      int node  = 0;
      int steps = 0;
      int k     = 0;
      int vecs[$];
      int ecode;
      int eab;
      forever begin
         if (node >= 11) begin
            ecode = (node - 15 + 12) % 12;
            eab   = 0;
            break;
         end else if (steps == limit) begin
            ecode = 15;
            eab   = 1;
            break;
         end
         vecs.push_back(node);
         node = 2 * node + 1 + int'(pat[steps]);
         steps++;
      end
      exp_code_q.push_back(ecode);
      exp_abort_q.push_back(eab);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(bz && !vv, "R2 busy, no vector yet", int'(bz), 1);
      forever begin
         if (dn) break;
         if (vv) begin
            chk(int'(vi) == vecs[k], "R4 vector index", int'(vi), vecs[k]);
            for (int w = 0; w < lat; w++) begin
               if (poke && k == 0) start = 1'b1; // R7: start while busy
               @(negedge clk);
               start = 1'b0;
               chk(vv && int'(vi) == vecs[k], "R3 request held", int'(vi), vecs[k]);
            end
            resp_valid = 1'b1;
            resp_fail  = pat[k];
            @(negedge clk);
            resp_valid = 1'b0;
            k++;
         end else begin
            @(negedge clk);
         end
      end
      chk(k == vecs.size(), "R6 test count", k, vecs.size());
      if (limit > 4) chk(k >= 3 && k <= 4, "R6 depth bound", k, 4);
   endtask

   initial begin
      #400000;
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!vv0 && !vv1, "R1 vec_valid low", int'(vv0), 0);
      chk(!b0 && !b1, "R1 busy low", int'(b0), 0);
      chk(!d0 && !d1, "R1 done low", int'(d0), 0);

      // R3: stray response while idle has no effect
      resp_valid = 1'b1;
      resp_fail  = 1'b1;
      @(negedge clk);
      resp_valid = 1'b0;
      @(negedge clk);
      chk(!vv0 && !b0 && !d0, "R3 idle response ignored", int'(b0), 0);

      // R5: all-pass path gives the no-fault code
      run_walk(4'b0000, 0, 1'b0, 100);
      repeat (2) @(negedge clk);

      // R4 R5: every response pattern, with varied latency
      for (int p = 0; p < 16; p++) begin
         run_walk(4'(p), p % 3, 1'b0, 100);
         @(negedge clk);
      end

      // R7: start raised while a request is pending
      run_walk(4'b0110, 3, 1'b1, 100);
      @(negedge clk);
      run_walk(4'b1001, 2, 1'b1, 100);
      @(negedge clk);

      // R9: back-to-back walks, start in the done cycle
      run_walk(4'b0011, 1, 1'b0, 100);
      run_walk(4'b1100, 0, 1'b0, 100);
      run_walk(4'b0101, 1, 1'b0, 100);
      repeat (3) @(negedge clk);
      chk(!b0 && exp_code_q.size() == 0, "R9 all walks completed", exp_code_q.size(), 0);

      // R8: step-limited instance
      sel = 1'b1;
      @(negedge clk);
      run_walk(4'b0000, 1, 1'b0, 3);
      @(negedge clk);
      run_walk(4'b0001, 0, 1'b0, 3);
      @(negedge clk);
      run_walk(4'b1111, 1, 1'b0, 3);
      repeat (3) @(negedge clk);
      chk(exp_code_q.size() == 0, "R8 scoreboard drained", exp_code_q.size(), 0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule